// File: doc/BRIEF.md
# Ping-Pong Coefficient Bank Updater

This block refreshes the spatial filter coefficients of one stereo stream among N streams while that stream keeps filtering. Each stream owns two filters, left and right, and each filter owns a pair of coefficient banks of 200 signed 16-bit entries. At any time one bank of a pair feeds the FIR datapath and the other one can be written. A start pulse carries a stream number, an azimuth and an elevation. The controller then streams 200 left-channel taps followed by 200 right-channel taps out of a large external coefficient store into the writable banks of that stream, and finally flips the stream's select bit.

The external store has a fixed read latency of one cycle. Addresses and write targets are pipelined so that one coefficient lands in a bank on every cycle. An update therefore keeps the block busy for 401 cycles. A bank pair does not follow the select bit at once. It captures the select bit only on its filter's done pulse, so a single filter output never mixes taps from two directions.

Top module: `coef_bank_updater`

## Requirements
- R1: While loading, the external address for channel c (0 left, 1 right), azimuth a, elevation e and tap t (a and e in 0..24, t in 0..199) is t + 200*e + 5000*a + 125000*c. The address for issue cycle k (k = 1..400, counted from the first cycle after the accepted start) belongs to channel (k-1)/200 and tap (k-1)%200.
- R2: The data returned one cycle after an address is written into the bank at that address's tap, and exactly one coefficient is written per cycle. The written bank is the one whose index equals the stream's current select bit.
- R3: The write enables are indexed 2*s for the left filter of stream s and 2*s+1 for its right filter. For cycles 2..201 only the left enable is high, for cycles 202..401 only the right enable is high, and at most one enable is ever high.
- R4: The tap counter runs from 0 to 199 and restarts at 0 when the right channel begins.
- R5: A filter's FIR read port returns the bank whose index differs from the select value latched by that filter. The banks of streams that are not being updated are untouched.
- R6: When the last right tap is written, the select bit of the updated stream inverts, and no other select bit changes. The new value is visible at cycle 402.
- R7: Each bank pair captures its stream's select bit only on a cycle where its own done input is high. Before that pulse the FIR keeps reading the previous coefficient set. A done pulse with no pending flip leaves the FIR data unchanged.
- R8: busy is high for cycles 1..401 of an update. A start pulse that arrives while busy is high is ignored, and so are its stream, azimuth and elevation.
- R9: After reset all select bits are 0, all write enables are 0 and busy is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | One-cycle request for an update |
| stream_sel | input | SW | Stream to update |
| azimuth | input | DIR_W | Azimuth index 0..24 |
| elevation | input | DIR_W | Elevation index 0..24 |
| ext_addr | output | EXT_AW | Read address to the external coefficient store |
| ext_rdata | input | W | Store data, valid one cycle after its address |
| fir_done | input | 2*N | Done pulse from each FIR (index 2*s+c) |
| fir_rd_addr | input | 2*N*TAP_W | Tap read address from each FIR |
| fir_coef | output | 2*N*W | Coefficient returned to each FIR |
| wr_en | output | 2*N | Bank write enable per filter |
| sel | output | N | Writable-bank select per stream |
| busy | output | 1 | Update in progress |

## Verification
The bench looks at the seam between channels. A counter that skips its restart, or a write enable that switches one cycle early or late, puts right taps at left addresses, and the per-cycle address and enable comparison catches this. It uses the largest azimuth and elevation so that a truncated address or a wrong radix shows up. It pulses done on only one filter of a stream to show that a design which follows the select bit directly would hand the FIR half-loaded or early coefficients. It also issues a start in the middle of an update, which a design without the busy guard would accept and use to corrupt the running update.

// File: rtl/cbu_pkg.sv
package cbu_pkg;

  // Mixed-radix index {channel, azimuth, elevation, tap} into the flat store.
  function automatic int unsigned coef_addr(input int unsigned ch,
                                            input int unsigned az,
                                            input int unsigned el,
                                            input int unsigned tap,
                                            input int unsigned dirs,
                                            input int unsigned taps);
    return ((ch * dirs + az) * dirs + el) * taps + tap;
  endfunction

  typedef enum logic {ST_IDLE, ST_LOAD} upd_state_t;

endpackage

// File: rtl/cbu_seq.sv
module cbu_seq
  import cbu_pkg::*;
#(
  parameter int N      = 2,
  parameter int TAPS   = 200,
  parameter int DIRS   = 25,
  parameter int SW     = 1,
  parameter int DIR_W  = 5,
  parameter int TAP_W  = 8,
  parameter int EXT_AW = 18
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [SW-1:0]     stream_sel,
  input  logic [DIR_W-1:0]  azimuth,
  input  logic [DIR_W-1:0]  elevation,
  output logic [EXT_AW-1:0] ext_addr,
  output logic [2*N-1:0]    wr_en,
  output logic [TAP_W-1:0]  wr_tap,
  output logic [N-1:0]      sel,
  output logic              busy
);

  upd_state_t        st;
  logic [TAP_W-1:0]  cnt;
  logic              ch;
  logic [SW-1:0]     lat_s;
  logic [DIR_W-1:0]  lat_az, lat_el;
  logic              wv, wch, wlast;
  logic [TAP_W-1:0]  wtap;
  logic [N-1:0]      sel_q;

  // named internal events
  logic accept, issue_fire, issue_last_tap, write_fire, update_finish;

  assign busy           = (st == ST_LOAD) || wv;
  assign accept         = start && !busy;
  assign issue_fire     = (st == ST_LOAD);
  assign issue_last_tap = (cnt == TAP_W'(TAPS - 1));
  assign write_fire     = wv;
  assign update_finish  = wv && wlast;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= ST_IDLE;
      cnt    <= '0;
      ch     <= 1'b0;
      lat_s  <= '0;
      lat_az <= '0;
      lat_el <= '0;
      wv     <= 1'b0;
      wch    <= 1'b0;
      wlast  <= 1'b0;
      wtap   <= '0;
      sel_q  <= '0;
    end else begin
      if (accept) begin
        st     <= ST_LOAD;
        cnt    <= '0;
        ch     <= 1'b0;
        lat_s  <= stream_sel;
        lat_az <= azimuth;
        lat_el <= elevation;
      end else if (issue_fire) begin
        cnt <= issue_last_tap ? '0 : cnt + 1'b1;
        if (issue_last_tap) begin
          if (ch) st <= ST_IDLE;
          else    ch <= 1'b1;
        end
      end
      // one-cycle pipeline matching the store's read latency
      wv    <= issue_fire;
      wtap  <= cnt;
      wch   <= ch;
      wlast <= issue_fire && ch && issue_last_tap;
      if (update_finish) sel_q[lat_s] <= ~sel_q[lat_s];
    end
  end

  always_comb begin
    ext_addr = '0;
    if (issue_fire)
      ext_addr = EXT_AW'(coef_addr(int'(ch), int'(lat_az), int'(lat_el),
                                   int'(cnt), DIRS, TAPS));
  end

  always_comb begin
    wr_en = '0;
    if (write_fire) wr_en[2 * int'(lat_s) + int'(wch)] = 1'b1;
  end

  assign wr_tap = wtap;
  assign sel    = sel_q;

  // R3: never two filters written at once
  assert_we_onehot_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(wr_en));

  // R4: tap counter stays inside the bank
  assert_cnt_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
    int'(cnt) < TAPS);

  // R4: right channel starts at tap 0 right after left tap 199
  assert_restart_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_fire && !ch && issue_last_tap) |=> (ch && cnt == '0));

  // R6: finishing flips exactly one select bit
  assert_sel_flip_R6: assert property (@(posedge clk) disable iff (!rst_n)
    update_finish |=> ($countones(sel ^ $past(sel)) == 1));

  // R6: select bits hold otherwise
  assert_sel_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !update_finish |=> $stable(sel));

  // R8: start during busy leaves the captured request alone
  assert_ignore_start_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> ($stable(lat_s) && $stable(lat_az) && $stable(lat_el)));

endmodule

// File: rtl/cbu_bank_pair.sv
module cbu_bank_pair #(
  parameter int TAPS  = 200,
  parameter int W     = 16,
  parameter int TAP_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [TAP_W-1:0] waddr,
  input  logic [W-1:0]     wdata,
  input  logic             sel_in,
  input  logic             fir_done,
  input  logic [TAP_W-1:0] rd_addr,
  output logic [W-1:0]     rd_coef
);

  logic [W-1:0] mem [2][TAPS];
  logic         act;
  logic         rd_ok;

  always_ff @(posedge clk) begin
    if (!rst_n)        act <= 1'b0;
    else if (fir_done) act <= sel_in;
  end

  always_ff @(posedge clk) begin
    if (we) mem[sel_in][waddr] <= wdata;
  end

  assign rd_ok   = int'(rd_addr) < TAPS;
  assign rd_coef = rd_ok ? mem[~act][rd_addr] : '0;

  // R7: the FIR-side select moves only on done
  assert_latch_on_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !fir_done |=> $stable(act));

  // R2: writes stay inside the bank
  assert_waddr_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
    we |-> int'(waddr) < TAPS);

endmodule

// File: rtl/coef_bank_updater.sv
module coef_bank_updater #(
  parameter int N    = 2,
  parameter int TAPS = 200,
  parameter int DIRS = 25,
  parameter int W    = 16,
  localparam int SW     = (N > 1) ? $clog2(N) : 1,
  localparam int DIR_W  = $clog2(DIRS),
  localparam int TAP_W  = $clog2(TAPS),
  localparam int EXT_AW = $clog2(2 * DIRS * DIRS * TAPS)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start,
  input  logic [SW-1:0]        stream_sel,
  input  logic [DIR_W-1:0]     azimuth,
  input  logic [DIR_W-1:0]     elevation,
  output logic [EXT_AW-1:0]    ext_addr,
  input  logic [W-1:0]         ext_rdata,
  input  logic [2*N-1:0]       fir_done,
  input  logic [2*N*TAP_W-1:0] fir_rd_addr,
  output logic [2*N*W-1:0]     fir_coef,
  output logic [2*N-1:0]       wr_en,
  output logic [N-1:0]         sel,
  output logic                 busy
);

  logic [TAP_W-1:0] wr_tap;

  cbu_seq #(
    .N(N), .TAPS(TAPS), .DIRS(DIRS), .SW(SW),
    .DIR_W(DIR_W), .TAP_W(TAP_W), .EXT_AW(EXT_AW)
  ) u_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .stream_sel(stream_sel),
    .azimuth(azimuth), .elevation(elevation), .ext_addr(ext_addr),
    .wr_en(wr_en), .wr_tap(wr_tap), .sel(sel), .busy(busy)
  );

  for (genvar f = 0; f < 2 * N; f++) begin : g_filter
    cbu_bank_pair #(.TAPS(TAPS), .W(W), .TAP_W(TAP_W)) u_pair (
      .clk(clk),
      .rst_n(rst_n),
      .we(wr_en[f]),
      .waddr(wr_tap),
      .wdata(ext_rdata),
      .sel_in(sel[f / 2]),
      .fir_done(fir_done[f]),
      .rd_addr(fir_rd_addr[f*TAP_W +: TAP_W]),
      .rd_coef(fir_coef[f*W +: W])
    );
  end

endmodule

// File: tb/coef_bank_updater_test.sv
`timescale 1ns/1ps
module coef_bank_updater_test;

  localparam int N = 2, TAPS = 200, DIRS = 25, W = 16;
  localparam int TAP_W = 8, EXT_AW = 18;

  logic                 clk = 1'b0;
  logic                 rst_n = 1'b0;
  logic                 start = 1'b0;
  logic [0:0]           stream_sel = '0;
  logic [4:0]           azimuth = '0, elevation = '0;
  logic [EXT_AW-1:0]    ext_addr;
  logic [W-1:0]         ext_rdata = '0;
  logic [2*N-1:0]       fir_done = '0;
  logic [2*N*TAP_W-1:0] fir_rd_addr = '0;
  logic [2*N*W-1:0]     fir_coef;
  logic [2*N-1:0]       wr_en;
  logic [N-1:0]         sel;
  logic                 busy;

  int checks = 0, errors = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  coef_bank_updater uut (
    .clk(clk), .rst_n(rst_n), .start(start), .stream_sel(stream_sel),
    .azimuth(azimuth), .elevation(elevation), .ext_addr(ext_addr),
    .ext_rdata(ext_rdata), .fir_done(fir_done), .fir_rd_addr(fir_rd_addr),
    .fir_coef(fir_coef), .wr_en(wr_en), .sel(sel), .busy(busy)
  );

  // store contents as a function of address
  function automatic logic [15:0] store_val(int a);
    int v;
    v = (a * 40503) ^ (a >>> 5);
    return v[15:0];
  endfunction

  function automatic int exp_addr(int c, int az, int el, int tap);
    return c * 125000 + az * 5000 + el * 200 + tap;
  endfunction

  // external store, one cycle read latency
  always @(posedge clk) ext_rdata <= store_val(int'(ext_addr));

  task automatic check(bit ok, string req, string what, int act, int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
    end
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(sel == '0, "R9", "select after reset", int'(sel), 0);
    check(wr_en == '0, "R9", "write enables after reset", int'(wr_en), 0);
    check(busy == 1'b0, "R9", "busy after reset", int'(busy), 0);
  endtask

  // one update with cycle-by-cycle checks; inject>=0 pulses a stray start
  task automatic t_update(int s, int az, int el, int inject);
    int bad_addr = 0, bad_we = 0, bad_busy = 0;
    int fa = 0, fe = 0, fx = 0;
    logic [N-1:0] sel0;
    logic [2*N-1:0] we_exp;
    sel0 = sel;
    @(negedge clk);
    start = 1'b1; stream_sel = 1'(s); azimuth = 5'(az); elevation = 5'(el);
    @(negedge clk);
    start = 1'b0;
    for (int j = 1; j <= 402; j++) begin
      if (j <= 400) begin
        if (int'(ext_addr) != exp_addr((j-1)/200, az, el, (j-1)%200)) begin
          if (bad_addr == 0) begin fa = int'(ext_addr);
            fe = exp_addr((j-1)/200, az, el, (j-1)%200); end
          bad_addr++;
        end
      end
      we_exp = '0;
      if (j >= 2 && j <= 201) we_exp[2*s] = 1'b1;
      if (j >= 202 && j <= 401) we_exp[2*s+1] = 1'b1;
      if (wr_en != we_exp) begin
        if (bad_we == 0) fx = j;
        bad_we++;
      end
      if (busy != (j <= 401)) bad_busy++;
      if (j == 100 && inject >= 0) begin
        start = 1'b1; stream_sel = 1'(inject); azimuth = 5'd1; elevation = 5'd2;
      end else begin
        start = 1'b0;
      end
      @(negedge clk);
    end
    check(bad_addr == 0, "R1", "store address sequence", fa, fe);
    check(bad_we == 0, "R3", "write enable pattern, first bad cycle", fx, 0);
    check(bad_busy == 0, "R8", "busy window mismatches", bad_busy, 0);
    sel0[s] = ~sel0[s];
    check(sel == sel0, "R6", "select after update", int'(sel), int'(sel0));
  endtask

  // read all taps of one filter and compare with a direction's set
  task automatic t_read(int f, int az, int el, string req, string what);
    int bad = 0, av = 0, ev = 0;
    for (int t = 0; t < TAPS; t++) begin
      fir_rd_addr[f*TAP_W +: TAP_W] = 8'(t);
      #1;
      if (fir_coef[f*W +: W] != store_val(exp_addr(f % 2, az, el, t))) begin
        if (bad == 0) begin av = int'(fir_coef[f*W +: W]);
          ev = int'(store_val(exp_addr(f % 2, az, el, t))); end
        bad++;
      end
    end
    check(bad == 0, req, what, av, ev);
  endtask

  task automatic t_done(logic [2*N-1:0] mask);
    @(negedge clk);
    fir_done = mask;
    @(negedge clk);
    fir_done = '0;
  endtask

  initial begin
    t_reset();

    // first load of stream 0, checked per cycle (R1 R2 R3 R4 R6 R8)
    t_update(0, 3, 7, -1);
    t_done(4'b0011);
    t_read(0, 3, 7, "R2", "left taps after done, tap order R4");
    t_read(1, 3, 7, "R2", "right taps after done, tap order R4");

    // corner direction, stray start from stream 1 mid-update (R8)
    t_update(0, 24, 24, 1);
    check(sel[1] == 1'b0, "R8", "stray start left stream 1 select", int'(sel[1]), 0);
    t_read(0, 3, 7, "R7", "left still old before done");
    t_read(1, 3, 7, "R7", "right still old before done");
    t_done(4'b0001);
    t_read(0, 24, 24, "R7", "left new after its own done");
    t_read(1, 3, 7, "R7", "right old without its done");
    t_done(4'b0010);
    t_read(1, 24, 24, "R7", "right new after its done");

    // stream 1, lowest direction; stream 0 must stay as is (R5)
    t_update(1, 0, 0, -1);
    t_done(4'b1100);
    t_read(2, 0, 0, "R5", "stream 1 left");
    t_read(3, 0, 0, "R5", "stream 1 right");
    t_read(0, 24, 24, "R5", "stream 0 left untouched");
    t_read(1, 24, 24, "R5", "stream 0 right untouched");

    // done with nothing pending changes nothing (R7)
    t_done(4'b1111);
    t_read(2, 0, 0, "R7", "idle done keeps stream 1");
    t_read(0, 24, 24, "R7", "idle done keeps stream 0");
    check(sel == 2'b10, "R6", "select after idle done", int'(sel), 2);

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule